// File: doc/BRIEF.md
# Parameterized GPIO Bank with Level-Compare Interrupts

This block is a bank of general-purpose pins behind a small word-addressed register bus. For every pin it keeps a driven value, a drive enable, a function-select bit, a pull-up enable, a pull-down enable, an interrupt enable and a reference level. Pad inputs are brought into the clock domain through a two-stage synchronizer, and the synchronized value is both readable and used for interrupt generation. The pin count is a parameter: 16 by default, and a 5-pin build is the same RTL.

A pin requests an interrupt while its synchronized level differs from its reference bit and its enable bit is set. All requests are OR-ed into one interrupt line, which a single global enable bit gates. There is no edge hardware. Software gets edge behaviour by rewriting the reference bit to the level it has just observed. That clears the request at once, and the next change of the pin raises it again.

Top module: `pin_ctrl_bank`

## Requirements
- R1: While reset is asserted and right after it is released, every register reads zero, pad_oe, pad_out, pad_func, pad_pu and pad_pd are all zero, and irq is 0.
- R2: A bus write (bus_sel=1, bus_wr=1) to a register takes effect at the next rising clock edge and reads back afterwards. Only bits [NPIN-1:0] are stored, and higher bits read 0. The offsets are: 0x04 output value, 0x08 drive enable, 0x0C function select, 0x10 pull-up, 0x14 pull-down, 0x18 interrupt enable, 0x1C reference level.
- R3: pad_oe equals the drive-enable register. pad_out carries the output-value bit only where the drive-enable bit is 1, and is 0 elsewhere.
- R4: A pad_in change is seen at offset 0x00 after exactly two rising edges, not after one.
- R5: A write to offset 0x00 has no effect. A read of an address that is not word-aligned or lies above 0x20 returns 0.
- R6: irq is 1 exactly when the global enable is set and (synchronized input XOR reference) AND interrupt-enable is nonzero.
- R7: Writing the reference register with a value equal to the current synchronized input drops irq at the edge of that write.
- R8: Bit 0 at offset 0x20 is the global interrupt enable, and the other bits there are not stored. With it at 0, irq stays 0.
- R9: The pull-up and pull-down enables are independent, may both be set on the same pin, and appear on pad_pu and pad_pd.
- R10: pad_func follows the function-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| pad_in | input | NPIN | Asynchronous pad levels |
| pad_out | output | NPIN | Value driven on enabled pads |
| pad_oe | output | NPIN | Per-pad drive enable |
| pad_func | output | NPIN | Per-pad function select |
| pad_pu | output | NPIN | Per-pad pull-up enable |
| pad_pd | output | NPIN | Per-pad pull-down enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The properties assume bus inputs change only away from the rising edge and are stable across it. They also assume pad_in is sampled cleanly by the first synchronizer stage. The bench therefore drives every input on the falling edge. The reference-rewrite property holds only while the synchronized input stays constant over the write edge, and the bench keeps pad_in steady during every reference write.

// File: rtl/pin_ctrl_pkg.sv
package pin_ctrl_pkg;
   localparam int ADR_IN   = 'h00;
   localparam int ADR_GIEN = 'h20;
   // per-pin register slots, slot i lives at byte offset 4*(i+1)
   localparam int SLOT_OUT  = 0;
   localparam int SLOT_OE   = 1;
   localparam int SLOT_FUNC = 2;
   localparam int SLOT_PU   = 3;
   localparam int SLOT_PD   = 4;
   localparam int SLOT_MASK = 5;
   localparam int SLOT_POL  = 6;
   localparam int NSLOT     = 7;

   function automatic int slot_addr(input int s);
      return 4 * (s + 1);
   endfunction
endpackage

// File: rtl/pin_ctrl_sync.sv
module pin_ctrl_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pin_ctrl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/pin_ctrl_regs.sv
module pin_ctrl_regs
   import pin_ctrl_pkg::*;
#(
   parameter int NPIN = 16,
   parameter int AW   = 8,
   parameter int DW   = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sel,
   input  logic                       wr,
   input  logic [AW-1:0]              addr,
   input  logic [NPIN-1:0]            wdata_lo,
   input  logic                       wdata_b0,
   input  logic [NPIN-1:0]            in_sync,
   output logic [NSLOT-1:0][NPIN-1:0] slot_q,
   output logic                       gien_q,
   output logic [DW-1:0]              rdata
);
   logic wen;
   assign wen = sel & wr;

   genvar g;
   generate
      for (g = 0; g < NSLOT; g++) begin : g_slot
         logic [NPIN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  q <= '0;
            else if (wen && addr == AW'(slot_addr(g)))   q <= wdata_lo;
         end
         assign slot_q[g] = q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                gien_q <= 1'b0;
      else if (wen && addr == AW'(ADR_GIEN))     gien_q <= wdata_b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == AW'(ADR_IN))   rdata[NPIN-1:0] = in_sync;
      if (addr == AW'(ADR_GIEN)) rdata[0]        = gien_q;
      for (int i = 0; i < NSLOT; i++) begin
         if (addr == AW'(slot_addr(i))) rdata[NPIN-1:0] = slot_q[i];
      end
   end
endmodule

// File: rtl/pin_ctrl_irq.sv
module pin_ctrl_irq #(
   parameter int NPIN = 16
) (
   input  logic [NPIN-1:0] level,
   input  logic [NPIN-1:0] ref_lvl,
   input  logic [NPIN-1:0] enable,
   input  logic            gien,
   output logic [NPIN-1:0] pending,
   output logic            irq
);
   assign pending = (level ^ ref_lvl) & enable;
   assign irq     = gien & (|pending);
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
   import pin_ctrl_pkg::*;
#(
   parameter int NPIN = 16,
   parameter int AW   = 8,
   parameter int DW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_sel,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NPIN-1:0] pad_in,
   output logic [NPIN-1:0] pad_out,
   output logic [NPIN-1:0] pad_oe,
   output logic [NPIN-1:0] pad_func,
   output logic [NPIN-1:0] pad_pu,
   output logic [NPIN-1:0] pad_pd,
   output logic            irq
);
   generate
      if (NPIN < 1 || NPIN > DW) begin : g_bad_npin
         $error("pin_ctrl_bank: NPIN must lie in 1..DW");
      end
      if (AW < 6) begin : g_bad_aw
         $error("pin_ctrl_bank: AW too narrow for the register map");
      end
      if (NPIN < DW) begin : g_spare
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^bus_wdata[DW-1:NPIN];
      end
   endgenerate

   logic [NPIN-1:0]            in_sync;
   logic [NSLOT-1:0][NPIN-1:0] slot_q;
   logic                       gien;
   logic [NPIN-1:0]            irq_mask;
   logic [NPIN-1:0]            pending;

   pin_ctrl_sync #(.W(NPIN), .STAGES(2)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pad_in),
      .dout (in_sync)
   );

   pin_ctrl_regs #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (bus_sel),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata_lo(bus_wdata[NPIN-1:0]),
      .wdata_b0(bus_wdata[0]),
      .in_sync (in_sync),
      .slot_q  (slot_q),
      .gien_q  (gien),
      .rdata   (bus_rdata)
   );

   assign irq_mask = slot_q[SLOT_MASK];

   pin_ctrl_irq #(.NPIN(NPIN)) u_irq (
      .level  (in_sync),
      .ref_lvl(slot_q[SLOT_POL]),
      .enable (irq_mask),
      .gien   (gien),
      .pending(pending),
      .irq    (irq)
   );

   assign pad_oe   = slot_q[SLOT_OE];
   assign pad_out  = slot_q[SLOT_OUT] & slot_q[SLOT_OE];
   assign pad_func = slot_q[SLOT_FUNC];
   assign pad_pu   = slot_q[SLOT_PU];
   assign pad_pd   = slot_q[SLOT_PD];
endmodule

// File: rtl/pin_ctrl_bank_chk.sv
module pin_ctrl_bank_chk #(
   parameter int NPIN = 16,
   parameter int AW   = 8,
   parameter int DW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_sel,
   input logic            bus_wr,
   input logic [AW-1:0]   bus_addr,
   input logic [NPIN-1:0] wdata_lo,
   input logic [DW-1:0]   bus_rdata,
   input logic [NPIN-1:0] pad_in,
   input logic [NPIN-1:0] pad_oe,
   input logic            irq,
   input logic [NPIN-1:0] in_sync,
   input logic [NPIN-1:0] mask_q,
   input logic            gien_q
);
   logic [1:0] since_rst;
   logic       mapped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr <= AW'('h20));

   AST_WR_DRIVE_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == AW'('h08)) |=> pad_oe == $past(wdata_lo)); // R2

   AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> in_sync == $past(pad_in, 2)); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !mapped) |-> bus_rdata == '0); // R5

   AST_NO_ENABLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq); // R6

   AST_REF_REWRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == AW'('h1C) && wdata_lo == in_sync)
      |=> (!irq || in_sync != $past(in_sync))); // R7

   AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !gien_q |-> !irq); // R8
endmodule

bind pin_ctrl_bank pin_ctrl_bank_chk #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .wdata_lo (bus_wdata[NPIN-1:0]),
   .bus_rdata(bus_rdata),
   .pad_in   (pad_in),
   .pad_oe   (pad_oe),
   .irq      (irq),
   .in_sync  (in_sync),
   .mask_q   (irq_mask),
   .gien_q   (gien)
);

// File: tb/pin_ctrl_bank_test.sv
module pin_ctrl_bank_test;
   localparam int NPIN = 16;
   localparam int AW   = 8;
   localparam int DW   = 32;
   localparam int NVEC = 8;

   // {pad level, interrupt enable, reference, global enable}
   localparam logic [3*NPIN:0] VEC [NVEC] = '{
      {16'h0000, 16'hFFFF, 16'h0000, 1'b1},
      {16'h0001, 16'h0001, 16'h0000, 1'b1},
      {16'h0001, 16'h0001, 16'h0000, 1'b0},
      {16'h8000, 16'h7FFF, 16'h0000, 1'b1},
      {16'h8000, 16'h8000, 16'h0000, 1'b1},
      {16'h0000, 16'h0010, 16'h0010, 1'b1},
      {16'hA5A5, 16'hFFFF, 16'hA5A5, 1'b1},
      {16'hA5A5, 16'h0F00, 16'hA4A5, 1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_sel = 1'b0;
   logic            bus_wr = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic [NPIN-1:0] pad_in = '0;
   logic [NPIN-1:0] pad_out, pad_oe, pad_func, pad_pu, pad_pd;
   logic            irq;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   pin_ctrl_bank #(.NPIN(NPIN), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_func(pad_func), .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the write edge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #2;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic settle();
      @(posedge clk); @(posedge clk); @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] r;
      logic [NPIN-1:0] pin, msk, pol;
      logic ge;
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", {31'd0, irq}, 32'd0);
      chk("R1 oe in reset", {16'd0, pad_oe}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: every register zero after reset
      for (int i = 0; i <= 8; i++) begin
         rd(AW'(4 * i), r);
         chk("R1 register read", r, 32'd0);
      end
      chk("R1 pads", {16'd0, pad_out | pad_oe | pad_func | pad_pu | pad_pd}, 32'd0);
      chk("R1 irq", {31'd0, irq}, 32'd0);

      // R2: write and read back every per-pin register, upper bits dropped
      for (int i = 1; i <= 7; i++) begin
         wr(AW'(4 * i), 32'hABCD_0000 | (32'h1111 * i));
         rd(AW'(4 * i), r);
         chk("R2 readback", r, 32'h1111 * i);
      end
      // R10 function select, R9 independent pulls
      wr(8'h0C, 32'h0000_C3C3);
      chk("R10 pad_func", {16'd0, pad_func}, 32'h0000_C3C3);
      wr(8'h10, 32'h0000_00FF);
      wr(8'h14, 32'h0000_0F0F);
      chk("R9 pad_pu", {16'd0, pad_pu}, 32'h0000_00FF);
      chk("R9 pad_pd", {16'd0, pad_pd}, 32'h0000_0F0F);
      // R3: output only on enabled pins
      wr(8'h08, 32'h0000_00F0);
      wr(8'h04, 32'h0000_0FF0);
      chk("R3 pad_oe", {16'd0, pad_oe}, 32'h0000_00F0);
      chk("R3 pad_out", {16'd0, pad_out}, 32'h0000_00F0);
      wr(8'h18, 32'h0);
      wr(8'h1C, 32'h0);

      // R4: two-edge synchronizer
      pad_in = 16'h0000; settle(); @(negedge clk);
      pad_in = 16'h1234;
      @(posedge clk); @(negedge clk);
      rd(8'h00, r);
      chk("R4 after one edge", r, 32'h0);
      @(posedge clk); @(negedge clk);
      rd(8'h00, r);
      chk("R4 after two edges", r, 32'h1234);

      // R5: input register not writable, unmapped reads zero
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, r);
      chk("R5 write to input ignored", r, 32'h1234);
      rd(8'h24, r); chk("R5 unmapped 0x24", r, 32'h0);
      rd(8'h06, r); chk("R5 misaligned 0x06", r, 32'h0);
      rd(8'h40, r); chk("R5 unmapped 0x40", r, 32'h0);

      // R6: table of level/enable/reference/global patterns
      for (int v = 0; v < NVEC; v++) begin
         {pin, msk, pol, ge} = VEC[v];
         pad_in = pin;
         wr(8'h18, {16'd0, msk});
         wr(8'h1C, {16'd0, pol});
         wr(8'h20, {31'd0, ge});
         chk("R6 irq vector", {31'd0, irq}, {31'd0, ge & (|((pin ^ pol) & msk))});
         rd(8'h00, r);
         chk("R6 input vector", r, {16'd0, pin});
      end

      // R7: rewriting the reference clears the request, next change re-raises
      pad_in = 16'h0004;
      wr(8'h18, 32'h4);
      wr(8'h1C, 32'h0);
      wr(8'h20, 32'h1);
      chk("R7 pending before rewrite", {31'd0, irq}, 32'd1);
      wr(8'h1C, 32'h0000_0004);
      chk("R7 cleared at write edge", {31'd0, irq}, 32'd0);
      pad_in = 16'h0000;
      @(posedge clk); @(negedge clk);
      chk("R6 not yet after one edge", {31'd0, irq}, 32'd0);
      @(posedge clk); @(negedge clk);
      chk("R6 raised after change", {31'd0, irq}, 32'd1);

      // R8: only bit 0 of the global register counts
      wr(8'h20, 32'hFFFF_FFFE);
      chk("R8 gated off", {31'd0, irq}, 32'd0);
      rd(8'h20, r);
      chk("R8 global readback", r, 32'h0);
      wr(8'h20, 32'h1);
      chk("R8 gated on", {31'd0, irq}, 32'd1);
      rd(8'h20, r);
      chk("R8 global readback set", r, 32'h1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule